// File: doc/BRIEF.md
# Serial Register Port with Readback and Chaining

This block is the serial front end through which a host reaches the register file of an eight-channel converter control core. The host lowers chip-select and sends a 24-bit word on the serial clock, MSB first. The word holds a direction flag, a 5-bit register address and a 16-bit value. The word takes effect when chip-select rises. A write word produces a single-cycle write strobe toward the register file in the system clock domain.

A read word only names a register. The contents of that register come out on the serial data output during the next word. The host normally makes that next word a no-operation command, so that the read changes nothing. When devices are chained, a chain-enable input changes what the output carries. It then carries the bit that leaves the top of the input shift register, so words ripple on to the next device in the chain. The output enable is released whenever chip-select is high.

All serial pins pass through a two-flop synchronizer and are oversampled by the system clock. The serial clock must therefore run at one quarter of the system clock or slower. Control runs in a four-state machine:
- `ST_IDLE` goes to `ST_SHIFT` on *frame-open*, when the synchronized chip-select is low.
- `ST_SHIFT` goes to `ST_COMMIT` on *frame-accept*, when chip-select is high again and the edge count is valid.
- `ST_SHIFT` goes to `ST_IDLE` on *frame-drop*, when chip-select is high and the edge count is invalid.
- `ST_COMMIT` goes to `ST_FETCH` on *read-pending* for a read word.
- `ST_COMMIT` goes to `ST_IDLE` on *write-done* for any other word.
- `ST_FETCH` always goes back to `ST_IDLE` on *fetch-done*.

Top module: `spi_regport`

## Requirements
- R1: The input word is sampled MSB first on rising serial-clock edges while chip-select is low. Bit 23 is the direction flag (1 = read), bits 20:16 are the register address and bits 15:0 are the value. A valid write word gives exactly one `wr_stb` carrying that address and value.
- R2: With chaining off, a word is accepted only if exactly 24 rising edges occurred while chip-select was low. Any other count, such as 23, 25 or 48 edges, produces no strobe, no read and no pending readback.
- R3: Bits 22:21 of the input word have no effect on any decode. In the readback word the same positions are always 0.
- R4: A read word produces no strobe and presents its address on `rd_addr`. During the following word, the output shifts out {1, 00, address, `rd_data`} MSB first, one bit per rising edge, with bit 23 present before the first edge.
- R5: A write to address 1 with value bit 0 set is a no-operation and produces no strobe. A write to address 1 with bit 0 clear does strobe.
- R6: `sdo_en` is 0 whenever chip-select is high, and 1 while a word is being shifted.
- R7: With chaining on, the output before each rising edge is the top bit of the input shift register. Words therefore pass through with a delay of 24 edges. Any word whose edge count is a nonzero multiple of 24 is accepted, and the last 24 bits received are decoded.
- R8: The strobe lasts one system-clock cycle. It comes only after chip-select has risen and has passed the two-flop synchronizer, never while a word is being shifted.
- R9: In readback mode, a word that follows any word other than an accepted read shifts out all zeros.
- R10: After reset, `wr_stb` and `sdo_en` are 0, `rd_addr` is 0 and the readback word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| daisy_en | input | 1 | 1: output carries the shift-register top bit (chaining); 0: readback |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, data sampled on the rising edge |
| sdi | input | 1 | Serial data in |
| sdo_data | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output driver enable; 0 means high impedance |
| wr_stb | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 5 | Write address, valid with `wr_stb` |
| wr_data | output | 16 | Write value, valid with `wr_stb` |
| rd_addr | output | 5 | Address of the register selected for readback |
| rd_data | input | 16 | Register file contents at `rd_addr` |

## Verification
The output register is touched by three actions: the readback load in `ST_FETCH`, the clear at frame-accept or frame-drop, and the per-edge shift. A read word followed at once by the next word puts the load and the clear right next to each other. The bench makes this happen with back-to-back read and no-operation words, both well-formed and short. It then judges the result by comparing every sampled output bit against the expected readback word or against zeros. The no-operation decode and the write strobe share the `ST_COMMIT` cycle. The scoreboard queue therefore checks that a no-operation word leaves no strobe, while the write that follows it does produce one.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FETCH  = 2'd3
    } port_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int FRAME_W = 24,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_active,
    input  logic               bit_rise,
    input  logic               bit_in,
    input  logic               tx_load,
    input  logic               tx_clear,
    input  logic [FRAME_W-1:0] tx_word,
    output logic [FRAME_W-1:0] rx_word,
    output logic [CNT_W-1:0]   mod_cnt,
    output logic [1:0]         wraps,
    output logic               rx_msb,
    output logic               tx_msb
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] tx_q;

    // Input shift register and edge counting (count modulo the word length)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
            mod_cnt <= '0;
            wraps   <= '0;
        end else if (!frame_active) begin
            mod_cnt <= '0;
            wraps   <= '0;
        end else if (bit_rise) begin
            rx_word <= {rx_word[FRAME_W-2:0], bit_in};
            if (mod_cnt == LAST) begin
                mod_cnt <= '0;
                if (wraps != 2'd3) wraps <= wraps + 2'd1;
            end else begin
                mod_cnt <= mod_cnt + 1'b1;
            end
        end
    end

    // Output shift register: load beats clear beats shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (tx_load) begin
            tx_q <= tx_word;
        end else if (tx_clear) begin
            tx_q <= '0;
        end else if (frame_active && bit_rise) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign rx_msb = rx_word[FRAME_W-1];
    assign tx_msb = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_s,
    input  logic        frame_ok,
    input  logic        is_read,
    input  logic        is_nop,
    output port_state_e state,
    output logic        frame_active,
    output logic        capture,
    output logic        wr_fire,
    output logic        rd_latch,
    output logic        tx_load
);
    port_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n_s) nxt = ST_SHIFT;                      // frame-open
            ST_SHIFT:  if (cs_n_s)  nxt = frame_ok ? ST_COMMIT : ST_IDLE; // frame-accept / frame-drop
            ST_COMMIT: nxt = is_read ? ST_FETCH : ST_IDLE;              // read-pending / write-done
            ST_FETCH:  nxt = ST_IDLE;                                   // fetch-done
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_active = 1'b0;
        capture      = 1'b0;
        wr_fire      = 1'b0;
        rd_latch     = 1'b0;
        tx_load      = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SHIFT: begin
                frame_active = 1'b1;
                capture      = cs_n_s;
            end
            ST_COMMIT: begin
                wr_fire  = !is_read && !is_nop;
                rd_latch = is_read;
            end
            ST_FETCH:  tx_load = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int              FRAME_W  = 24,
    parameter int              ADDR_W   = 5,
    parameter int              DATA_W   = 16,
    parameter int              SYNC_N   = 2,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 5'h01,
    parameter int              NOP_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              daisy_en,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo_data,
    output logic              sdo_en,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int RW_POS = FRAME_W - 1;
    localparam int PAD_W  = FRAME_W - 1 - ADDR_W - DATA_W;
    localparam int CNT_W  = $clog2(FRAME_W);

    logic [2:0]         pins_s;
    logic               cs_n_s, sclk_s, sdi_s, sclk_d, sclk_rise;
    logic [FRAME_W-1:0] rx_word, frame_q, tx_word;
    logic [CNT_W-1:0]   mod_cnt;
    logic [1:0]         wraps;
    logic               rx_msb, tx_msb;
    logic               frame_ok, is_read, is_nop;
    logic               frame_active, capture, wr_fire, rd_latch, tx_load;
    port_state_e        state;

    spi_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_d;

    spi_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
        .bit_rise(sclk_rise), .bit_in(sdi_s), .tx_load(tx_load),
        .tx_clear(capture), .tx_word(tx_word), .rx_word(rx_word),
        .mod_cnt(mod_cnt), .wraps(wraps), .rx_msb(rx_msb), .tx_msb(tx_msb)
    );

    // Whole words only; a single word unless chaining is enabled
    assign frame_ok = (mod_cnt == '0) && (wraps != 2'd0) && (daisy_en || wraps == 2'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       frame_q <= '0;
        else if (capture) frame_q <= rx_word;
    end

    assign is_read = frame_q[RW_POS];
    assign wr_addr = frame_q[DATA_W +: ADDR_W];
    assign wr_data = frame_q[DATA_W-1:0];
    assign is_nop  = (wr_addr == CMD_ADDR) && wr_data[NOP_BIT];

    spi_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .frame_ok(frame_ok),
        .is_read(is_read), .is_nop(is_nop), .state(state),
        .frame_active(frame_active), .capture(capture), .wr_fire(wr_fire),
        .rd_latch(rd_latch), .tx_load(tx_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_addr <= '0;
        else if (rd_latch) rd_addr <= wr_addr;
    end

    assign tx_word  = {1'b1, {PAD_W{1'b0}}, rd_addr, rd_data};
    assign wr_stb   = wr_fire;
    assign sdo_data = daisy_en ? rx_msb : tx_msb;
    assign sdo_en   = ~cs_n & frame_active;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int                ADDR_W   = 5,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 5'h01,
    parameter int                NOP_BIT  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo_en,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr
);
    // R6
    sdo_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_en);

    // R8
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R8
    stb_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !sdo_en);

    // R5
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !((wr_addr == CMD_ADDR) && wr_data[NOP_BIT]));

    // R4
    rdaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> !sdo_en);
endmodule

bind spi_regport spi_regport_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .NOP_BIT(NOP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
);

// File: tb/tb_spi_regport.sv
module tb_spi_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        daisy_en = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo_data, sdo_en, wr_stb;
    logic [4:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [20:0] exp_q[$];

    always #4 clk = ~clk;

    // register file model
    assign rd_data = {3'b101, rd_addr, 8'h3C};

    spi_regport dut (
        .clk(clk), .rst_n(rst_n), .daisy_en(daisy_en), .cs_n(cs_n),
        .sclk(sclk), .sdi(sdi), .sdo_data(sdo_data), .sdo_en(sdo_en),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [23:0] rb_word(input logic [4:0] a);
        return {1'b1, 2'b00, a, 3'b101, a, 8'h3C};
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every strobe must match the oldest expected write
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R2/R5 unexpected strobe", {27'd0, wr_addr, wr_data}, 48'd0);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R1 strobe addr/data",
                      {27'd0, wr_addr, wr_data}, {27'd0, e});
            end
        end
    end

    // shifts the first n bits of v (from bit 47 down), returns sampled output
    task automatic send(input logic [47:0] v, input int n, output logic [47:0] got);
        int en_bad;
        en_bad = 0;
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = v[47-i];
            repeat (8) @(negedge clk);
            got[47-i] = sdo_data;
            if (sdo_en !== 1'b1) en_bad++;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        check(en_bad == 0, "R6 enable during frame", 48'(en_bad), 48'd0);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_en == 1'b0, "R6 high-Z after cs rise", {47'd0, sdo_en}, 48'd0);
        repeat (16) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] dc, input logic [4:0] a, input logic [15:0] d,
                      input bit expect_stb, output logic [23:0] got24);
        logic [47:0] g;
        if (expect_stb) exp_q.push_back({a, d});
        send({1'b0, dc, a, d, 24'd0}, 24, g);
        got24 = g[47:24];
    endtask

    task automatic rd(input logic [1:0] dc, input logic [4:0] a, output logic [23:0] got24);
        logic [47:0] g;
        send({1'b1, dc, a, 16'hFFFF, 24'd0}, 24, g);
        got24 = g[47:24];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [23:0] g;
        logic [47:0] g48;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(wr_stb == 1'b0 && sdo_en == 1'b0, "R10 outputs idle",
              {46'd0, wr_stb, sdo_en}, 48'd0);
        check(rd_addr == 5'd0, "R10 rd_addr", 48'(rd_addr), 48'd0);

        // R1 plain write; R10 readback word is zero after reset
        wr(2'b00, 5'h03, 16'h1234, 1'b1, g);
        check(g == 24'd0, "R10 readback zero after reset", 48'(g), 48'd0);
        // R3 don't-care bits set, write still decoded normally
        wr(2'b11, 5'h07, 16'hBEEF, 1'b1, g);
        check(g == 24'd0, "R9 zeros after write", 48'(g), 48'd0);

        // R4 read, then NOP carries the readback
        rd(2'b00, 5'h0A, g);
        check(rd_addr == 5'h0A, "R4 rd_addr", 48'(rd_addr), 48'h0A);
        wr(2'b00, 5'h01, 16'h0001, 1'b0, g);
        check(g == rb_word(5'h0A), "R4 readback word", 48'(g), 48'(rb_word(5'h0A)));

        // R5 command address with nop bit clear does strobe; R9 zeros after nop
        wr(2'b00, 5'h01, 16'h0002, 1'b1, g);
        check(g == 24'd0, "R9 zeros after nop", 48'(g), 48'd0);

        // R3 read with don't-care bits set: readback has them as 0
        rd(2'b11, 5'h05, g);
        wr(2'b00, 5'h01, 16'h0001, 1'b0, g);
        check(g == rb_word(5'h05), "R3 readback pad bits zero", 48'(g), 48'(rb_word(5'h05)));

        // R2 short and long frames discarded
        send({1'b0, 2'b00, 5'h09, 16'hAAAA, 24'd0}, 23, g48);
        send({1'b0, 2'b00, 5'h09, 16'hAAAA, 24'd0}, 25, g48);
        send({1'b1, 2'b00, 5'h06, 16'h0000, 24'd0}, 23, g48);
        check(rd_addr == 5'h05, "R2 short read ignored", 48'(rd_addr), 48'h05);
        wr(2'b00, 5'h01, 16'h0001, 1'b0, g);
        check(g == 24'd0, "R2 no readback after short read", 48'(g), 48'd0);
        send({24'h0B_4444, 24'h0B_5555}, 48, g48);

        // R7 chaining
        daisy_en = 1'b1;
        wr(2'b00, 5'h0C, 16'h5555, 1'b1, g);
        exp_q.push_back({5'h0E, 16'h2222});
        send({1'b0, 2'b00, 5'h0D, 16'h1111, 1'b0, 2'b00, 5'h0E, 16'h2222}, 48, g48);
        check(g48[47:24] == {1'b0, 2'b00, 5'h0C, 16'h5555}, "R7 previous word passed on",
              48'(g48[47:24]), 48'({1'b0, 2'b00, 5'h0C, 16'h5555}));
        check(g48[23:0] == {1'b0, 2'b00, 5'h0D, 16'h1111}, "R7 first word echoed",
              48'(g48[23:0]), 48'({1'b0, 2'b00, 5'h0D, 16'h1111}));
        daisy_en = 1'b0;

        repeat (20) @(negedge clk);
        // R8 strobe count matches exactly (one strobe per accepted write)
        check(exp_q.size() == 0, "R8 all strobes seen once", 48'(exp_q.size()), 48'd0);
        finish_run();
    end
endmodule